// File: doc/BRIEF.md
# Programmable Command Recovery Timer

This block sits beside the strobe generator of a card-slot bus controller and enforces a quiet interval after every command. Any of the four command strobes (memory read enable, memory write enable, I/O read, I/O write) opens a command. When the last strobe goes inactive, the block counts a programmed number of internal clock cycles and holds `busy` high for exactly that long. A requester asks for the next command on `cmd_req`. The block answers on `cmd_go` once the bus is free, and holds any request that arrives too early until then.

Two identical 8-bit timing registers hold the interval. Both are reached through an index/data port. The `cmd_set` input picks the register for each command. Its value is sampled when the command starts, so later register writes change only later commands. The interval is a coarse power-of-two weight times a 6-bit multiplier, plus one. It runs from 1 cycle up to 516097 cycles.

Top module: `cmd_recovery_timer`

## Requirements
- R1: Register set 0 is at index 0x3C and set 1 at index 0x3F. A write with `reg_wr` high stores `reg_wdata` at the clock edge. `reg_rdata` returns the register chosen by `reg_index` in the same cycle.
- R2: After reset, both registers read 0x03, which gives a recovery of 4 cycles.
- R3: The recovery length is R = weight × multiplier + 1. The multiplier is bits 5:0, unsigned. The weight comes from bits 7:6: 00 gives 1, 01 gives 16, 10 gives 256, 11 gives 8192.
- R4: `busy` rises at the clock edge where all strobes have gone inactive. It stays high for exactly R cycles, then falls.
- R5: Any strobe bit starts a command. The bits are: bit 0 memory read enable, bit 1 memory write enable, bit 2 I/O read, bit 3 I/O write.
- R6: `cmd_set` is sampled in the first cycle any strobe is high. Changing it later in the command has no effect on that command.
- R7: A register write made while a command or its recovery is in progress does not change that recovery. It applies from the next command.
- R8: A write to any index other than 0x3C or 0x3F leaves both registers unchanged. A read of such an index returns 0.
- R9: `cmd_go` is high in a cycle where a request is present and the bus is neither busy nor strobing. The request may be `cmd_req` or a held one. A `cmd_req` pulse that arrives while the bus is blocked is held. The held request is granted in the first cycle `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_index | input | 8 | Register index |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data for `reg_index` |
| cmd_set | input | 1 | Timing set selection for the command |
| cmd_strb | input | 4 | Active-high command strobes |
| cmd_req | input | 1 | Request for the next command |
| cmd_go | output | 1 | Grant to issue a command |
| busy | output | 1 | Recovery in progress |

## Verification
The hardest case to reach is a request that is held across a recovery. It must be granted in exactly the first free cycle, and nowhere else. The stimulus pulses `cmd_req` in the middle of a long recovery. It then samples `cmd_go` on the cycle `busy` is first seen low and on the cycle after. Two other cases are covered the same way: a register rewrite during recovery, and a `cmd_set` flip while a strobe is high. Both are placed inside a running command. The measured busy lengths are then compared against lengths computed from the old and new settings.

// File: rtl/crt_pkg.sv
package crt_pkg;
  localparam int unsigned REG_W     = 8;
  localparam int unsigned MULT_W    = 6;
  localparam int unsigned MAX_SHIFT = 13;
  localparam int unsigned CNT_W     = MULT_W + MAX_SHIFT;

  typedef struct packed {
    logic [1:0]        pre;
    logic [MULT_W-1:0] mult;
  } rec_cfg_t;

  function automatic logic [CNT_W-1:0] calc_len(input rec_cfg_t cfg);
    logic [CNT_W-1:0] base;
    base = CNT_W'(cfg.mult);
    case (cfg.pre)
      2'b00:   calc_len = base + 1'b1;
      2'b01:   calc_len = (base << 4) + 1'b1;
      2'b10:   calc_len = (base << 8) + 1'b1;
      default: calc_len = (base << MAX_SHIFT) + 1'b1;
    endcase
  endfunction
endpackage

// File: rtl/crt_regfile.sv
module crt_regfile
  import crt_pkg::*;
#(
  parameter int unsigned NSETS = 2,
  parameter logic [7:0]  IDX0  = 8'h3C,
  parameter logic [7:0]  IDX1  = 8'h3F,
  parameter logic [7:0]  RST_V = 8'h03
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [7:0]       idx,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata,
  output rec_cfg_t         cfg [NSETS]
);
  localparam logic [7:0] IDX_TAB [2] = '{IDX0, IDX1};

  logic [NSETS-1:0][REG_W-1:0] regs_q, regs_d;
  logic [NSETS-1:0]            hit;

  for (genvar g = 0; g < NSETS; g++) begin : g_set
    assign hit[g] = (idx == IDX_TAB[g]);
    assign cfg[g] = rec_cfg_t'(regs_q[g]);

    always_comb begin
      regs_d[g] = regs_q[g];
      if (wr && hit[g]) regs_d[g] = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) regs_q[g] <= RST_V;
      else        regs_q[g] <= regs_d[g];
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NSETS; i++)
      if (hit[i]) rdata = regs_q[i];
  end

  AST_OTHER_IDX_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && hit == '0) |=> $stable(regs_q)); // R8
endmodule

// File: rtl/crt_counter.sv
module crt_counter
  import crt_pkg::*;
#(
  parameter int unsigned STRB_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STRB_W-1:0] strb,
  input  rec_cfg_t          cfg_cur,
  output logic              strb_any,
  output logic              busy
);
  logic             strb_q;
  logic             start_evt, end_evt;
  logic [CNT_W-1:0] len_q, len_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             len_en;

  assign strb_any  = |strb;
  assign start_evt = strb_any & ~strb_q;
  assign end_evt   = ~strb_any & strb_q;
  assign len_en    = start_evt;
  assign len_d     = calc_len(cfg_cur);

  always_comb begin
    cnt_d = cnt_q;
    if (end_evt)            cnt_d = len_q;
    else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strb_q <= 1'b0;
      len_q  <= '0;
      cnt_q  <= '0;
    end else begin
      strb_q <= strb_any;
      if (len_en) len_q <= len_d;
      cnt_q  <= cnt_d;
    end
  end

  assign busy = (cnt_q != '0);

  AST_BUSY_ON_END: assert property (@(posedge clk) disable iff (!rst_n)
    end_evt |=> busy); // R4
  AST_LOAD_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    end_evt |=> (cnt_q == $past(len_q))); // R7
  AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !end_evt) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R4
  AST_LEN_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (len_q != '0)); // R3
endmodule

// File: rtl/crt_arbiter.sv
module crt_arbiter (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic blocked,
  input  logic busy,
  output logic go
);
  logic pend_q, pend_d;

  assign go = (req | pend_q) & ~blocked;

  always_comb begin
    pend_d = pend_q;
    if (go)                 pend_d = 1'b0;
    else if (req && blocked) pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  AST_GO_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> !busy); // R9
  AST_PEND_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && blocked) |=> pend_q); // R9
endmodule

// File: rtl/cmd_recovery_timer.sv
module cmd_recovery_timer
  import crt_pkg::*;
#(
  parameter int unsigned STRB_W = 4,
  parameter logic [7:0]  IDX0   = 8'h3C,
  parameter logic [7:0]  IDX1   = 8'h3F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [7:0]        reg_index,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              cmd_set,
  input  logic [STRB_W-1:0] cmd_strb,
  input  logic              cmd_req,
  output logic              cmd_go,
  output logic              busy
);
  localparam int unsigned NSETS = 2;

  logic     rst_s1_q, rst_s2_q;
  rec_cfg_t cfg [NSETS];
  rec_cfg_t cfg_cur;
  logic     strb_any;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end

  crt_regfile #(.NSETS(NSETS), .IDX0(IDX0), .IDX1(IDX1)) u_regs (
    .clk   (clk),
    .rst_n (rst_s2_q),
    .wr    (reg_wr),
    .idx   (reg_index),
    .wdata (reg_wdata),
    .rdata (reg_rdata),
    .cfg   (cfg)
  );

  assign cfg_cur = cmd_set ? cfg[1] : cfg[0];

  crt_counter #(.STRB_W(STRB_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_s2_q),
    .strb     (cmd_strb),
    .cfg_cur  (cfg_cur),
    .strb_any (strb_any),
    .busy     (busy)
  );

  crt_arbiter u_arb (
    .clk     (clk),
    .rst_n   (rst_s2_q),
    .req     (cmd_req),
    .blocked (busy | strb_any),
    .busy    (busy),
    .go      (cmd_go)
  );
endmodule

// File: tb/cmd_recovery_timer_tb_top.sv
module cmd_recovery_timer_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_index = 8'h00;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       cmd_set = 1'b0;
  logic [3:0] cmd_strb = 4'h0;
  logic       cmd_req = 1'b0;
  logic       cmd_go;
  logic       busy;

  int n_cmp = 0;
  int n_bad = 0;
  int exp_q[$];
  string tag_q[$];

  always #2 clk = ~clk;

  cmd_recovery_timer dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_index(reg_index),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cmd_set(cmd_set),
    .cmd_strb(cmd_strb), .cmd_req(cmd_req), .cmd_go(cmd_go), .busy(busy)
  );

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int len_of(input logic [7:0] v);
    int w;
    case (v[7:6])
      2'b00: w = 1;
      2'b01: w = 16;
      2'b10: w = 256;
      default: w = 8192;
    endcase
    return w * int'(v[5:0]) + 1;
  endfunction

  task automatic wr_reg(input logic [7:0] idx, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_index = idx; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_check(input logic [7:0] idx, input int exp, input string req);
    @(negedge clk);
    reg_index = idx;
    #1 check(req, int'(reg_rdata), exp);
  endtask

  // Driver: raise one strobe with a set, flip the set mid-command (R6), drop it.
  task automatic do_cmd(input logic set, input int bitn, input int exp, input string req);
    @(negedge clk);
    cmd_set = set; cmd_strb = 4'h0; cmd_strb[bitn] = 1'b1;
    exp_q.push_back(exp); tag_q.push_back(req);
    @(negedge clk);
    cmd_set = ~set;
    @(negedge clk);
    cmd_strb = 4'h0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // Monitor: measure every busy pulse and compare against the queue.
  initial begin
    int run;
    run = 0;
    forever begin
      @(negedge clk);
      if (busy) run++;
      else if (run != 0) begin
        if (exp_q.size() == 0) check("R4 unexpected busy", run, 0);
        else check({tag_q.pop_front(), " busy length"}, run, exp_q.pop_front());
        run = 0;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    rd_check(8'h3C, 8'h03, "R2 set0 reset");
    rd_check(8'h3F, 8'h03, "R2 set1 reset");
    #1 check("R2 busy at reset", int'(busy), 0);

    do_cmd(1'b0, 0, 4, "R2 R5 default length");
    drain();

    wr_reg(8'h3C, 8'h00);
    rd_check(8'h3C, 8'h00, "R1 set0 write");
    do_cmd(1'b0, 1, 1, "R3 R5 zero multiplier");
    drain();

    wr_reg(8'h3F, 8'h45);
    rd_check(8'h3F, 8'h45, "R1 set1 write");
    do_cmd(1'b1, 2, len_of(8'h45), "R3 R6 weight16");
    drain();

    wr_reg(8'h3C, 8'h81);
    do_cmd(1'b0, 3, len_of(8'h81), "R3 R5 weight256");
    drain();

    wr_reg(8'h3C, 8'hC1);
    do_cmd(1'b0, 0, len_of(8'hC1), "R3 weight8192");
    drain();

    wr_reg(8'h3C, 8'hBF);
    do_cmd(1'b0, 1, len_of(8'hBF), "R3 weight256 max mult");
    drain();

    // R8: other indexes
    wr_reg(8'h3D, 8'h77);
    wr_reg(8'h3E, 8'h11);
    rd_check(8'h3C, 8'hBF, "R8 set0 untouched");
    rd_check(8'h3F, 8'h45, "R8 set1 untouched");
    rd_check(8'h3D, 0, "R8 other index reads zero");

    // R7: rewrite during recovery
    do_cmd(1'b1, 2, len_of(8'h45), "R7 old value holds");
    repeat (10) @(negedge clk);
    wr_reg(8'h3F, 8'h00);
    drain();
    do_cmd(1'b1, 3, 1, "R7 new value next command");
    drain();

    // R9: direct grant while idle
    @(negedge clk);
    cmd_req = 1'b1;
    #1 check("R9 grant when idle", int'(cmd_go), 1);
    @(negedge clk);
    cmd_req = 1'b0;

    // R9: held request during a long recovery
    do_cmd(1'b0, 0, len_of(8'hBF), "R9 carrier command");
    repeat (20) @(negedge clk);
    cmd_req = 1'b1;
    #1 check("R9 no grant while busy", int'(cmd_go), 0);
    @(negedge clk);
    cmd_req = 1'b0;
    #1 check("R9 still held", int'(cmd_go), 0);
    while (busy) begin
      @(negedge clk);
    end
    check("R9 held grant first free cycle", int'(cmd_go), 1);
    @(negedge clk);
    check("R9 grant once", int'(cmd_go), 0);
    drain();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule